// File: doc/BRIEF.md
# Entity Mode Controller

This block tracks the operating situation of one supervised entity in a hierarchical supervision tree, such as a machine, a robot or an operation made up of subordinate entities. Two state machines run side by side. The working region follows the activation life cycle: stopped, armed (activation accepted and waiting for the children), running, and finished. The functioning region follows availability: normal, degraded, or faulted.

A start order is honoured only while the entity is not faulted. While armed or running, the block raises an activation request that goes down to its children. It moves from armed to running once the children satisfy the aggregation rule. Health travels the other way. Each child reports degraded and faulted levels, and these are combined under an AND or an OR rule chosen at instantiation. The combined result acts on the functioning region together with the entity's own health events. Every control state has its own output flag, so a parent or a monitor can see either region directly.

Top module: `entity_mode_ctrl`

## Requirements
- R1: After reset the working region is stopped (`wk_off`=1) and the functioning region is normal (`fn_normal`=1). `act_req` is 0.
- R2: A start order takes the working region from stopped to armed one cycle later. The order is ignored, and the region stays stopped, while the functioning region is faulted.
- R3: Armed moves to running on the next edge once the children allow it. With AND aggregation (`AGG_AND`=1) every bit of `child_ready` must be 1. With OR aggregation (`AGG_AND`=0) any bit is enough. Running is entered only from armed.
- R4: `activity_done` while running moves the working region to the finished state on the next edge. The finished state always returns to stopped one edge later.
- R5: A stop order moves the working region to stopped on the next edge from any state. Stop wins over a start order given in the same cycle.
- R6: The health events set the functioning region on the next edge. `ev_fault` selects faulted, `ev_degraded` selects degraded and `ev_normal` selects normal. When several are given together, faulted wins over degraded, and degraded wins over normal.
- R7: Child health is combined as follows. With AND, any child faulted makes the entity faulted, and any child degraded makes it degraded. With OR, the entity is faulted only when all children are faulted, and it is degraded when any child is degraded or faulted. The combined result acts like the matching health event.
- R8: If the functioning region is faulted while the working region is armed or running, the working region is stopped on the following edge.
- R9: In every cycle exactly one of `wk_off`, `wk_armed`, `wk_on`, `wk_end` is 1, and exactly one of `fn_normal`, `fn_degraded`, `fn_fault` is 1.
- R10: `act_req` is 1 exactly while the working region is armed or running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_cmd | input | 1 | Activation order |
| stop_cmd | input | 1 | Deactivation order |
| ev_normal | input | 1 | Entity's own health event: back to normal |
| ev_degraded | input | 1 | Entity's own health event: degraded |
| ev_fault | input | 1 | Entity's own health event: out of order |
| activity_done | input | 1 | Activity has reached its end |
| child_ready | input | N_CHILD | Per child: child is running |
| child_degraded | input | N_CHILD | Per child: child is degraded |
| child_fault | input | N_CHILD | Per child: child is out of order |
| act_req | output | 1 | Activation request forwarded to the children |
| wk_off | output | 1 | Working region: stopped |
| wk_armed | output | 1 | Working region: armed, waiting for the children |
| wk_on | output | 1 | Working region: running |
| wk_end | output | 1 | Working region: activity finished |
| fn_normal | output | 1 | Functioning region: normal |
| fn_degraded | output | 1 | Functioning region: degraded |
| fn_fault | output | 1 | Functioning region: out of order |

## Verification
Orders, health events and child levels are all registered once, so each flag responds on the first rising edge after the stimulus is applied. The one exception is the fault-forced stop of R8. It needs a second edge, because the working region reacts to the registered faulted state. The bench applies inputs on the falling edge and samples one full cycle later. For R8 it samples first after one edge, where running must still show together with faulted, and again after the second edge, where the working region must be stopped. One AND instance and one OR instance share every input, so each stimulus checks both aggregation rules together.

// File: rtl/emc_pkg.sv
// Package emc_pkg
// Shared state encodings for the entity mode controller.
// Assumes: the states of each region are enumerated densely from zero.
package emc_pkg;

    // Working region: activation life cycle of the entity.
    typedef enum logic [1:0] {
        WK_OFF   = 2'd0,
        WK_ARMED = 2'd1,
        WK_ON    = 2'd2,
        WK_END   = 2'd3
    } work_state_t;

    // Functioning region: availability of the entity.
    typedef enum logic [1:0] {
        FN_NORMAL   = 2'd0,
        FN_DEGRADED = 2'd1,
        FN_FAULT    = 2'd2
    } func_state_t;

endpackage

// File: rtl/emc_child_agg.sv
// Module emc_child_agg
// Combines child readiness and health under the AND or OR relation.
// Assumes: the child vectors are levels that stay valid while they apply;
// N_CHILD >= 1. Purely combinational.
module emc_child_agg #(
    parameter int N_CHILD = 3,
    parameter bit AGG_AND = 1'b1
) (
    input  logic [N_CHILD-1:0] child_ready,
    input  logic [N_CHILD-1:0] child_degraded,
    input  logic [N_CHILD-1:0] child_fault,
    output logic               agg_ready,
    output logic               agg_degraded,
    output logic               agg_fault
);

    generate
        if (AGG_AND) begin : g_and
            // AND relation: every child is needed, so one failure is enough.
            always_comb begin
                agg_ready    = &child_ready;
                agg_fault    = |child_fault;
                agg_degraded = |child_degraded;
            end
        end else begin : g_or
            // OR relation: any child suffices, so only total loss is a fault.
            always_comb begin
                agg_ready    = |child_ready;
                agg_fault    = &child_fault;
                agg_degraded = |(child_degraded | child_fault);
            end
        end
    endgenerate

endmodule

// File: rtl/emc_func_region.sv
// Module emc_func_region
// Functioning (availability) region: normal, degraded or faulted.
// Assumes: the hit inputs already merge the entity's own events with child
// health; the priority is fault over degraded over normal.
module emc_func_region
    import emc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hit_normal,
    input  logic        hit_degraded,
    input  logic        hit_fault,
    output func_state_t fn_state
);

    func_state_t fn_next;

    // Next-state selection with a fixed severity priority.
    always_comb begin
        fn_next = fn_state;
        if (hit_fault)
            fn_next = FN_FAULT;
        else if (hit_degraded)
            fn_next = FN_DEGRADED;
        else if (hit_normal)
            fn_next = FN_NORMAL;
    end

    // State register, cleared to normal by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fn_state <= FN_NORMAL;
        else
            fn_state <= fn_next;
    end

endmodule

// File: rtl/emc_work_region.sv
// Module emc_work_region
// Working (activation) region: off, armed, on, end.
// Assumes: fault_now is the registered functioning state (faulted), so a
// fault reaches this region one cycle after the functioning region updates.
module emc_work_region
    import emc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_cmd,
    input  logic        stop_cmd,
    input  logic        fault_now,
    input  logic        cond_ok,
    input  logic        activity_done,
    output work_state_t wk_state,
    output logic        act_req
);

    work_state_t wk_next;

    // Next-state logic; stop and an active fault preempt every other move.
    always_comb begin
        wk_next = wk_state;
        if (stop_cmd) begin
            wk_next = WK_OFF;
        end else begin
            unique case (wk_state)
                WK_OFF:   if (start_cmd && !fault_now) wk_next = WK_ARMED;
                WK_ARMED: if (fault_now)               wk_next = WK_OFF;
                          else if (cond_ok)            wk_next = WK_ON;
                WK_ON:    if (fault_now)               wk_next = WK_OFF;
                          else if (activity_done)      wk_next = WK_END;
                WK_END:                                wk_next = WK_OFF;
                default:                               wk_next = WK_OFF;
            endcase
        end
    end

    // State register plus a registered activation request for the children.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_state <= WK_OFF;
            act_req  <= 1'b0;
        end else begin
            wk_state <= wk_next;
            act_req  <= (wk_next == WK_ARMED) || (wk_next == WK_ON);
        end
    end

endmodule

// File: rtl/entity_mode_ctrl.sv
// Module entity_mode_ctrl (top)
// Mode controller for one entity of a supervision hierarchy: a working region
// and a functioning region run in parallel, child readiness and health are
// combined under the AND/OR relation, and every state has its own flag.
// Assumes: synchronous active-low reset; all inputs synchronous to clk.
module entity_mode_ctrl
    import emc_pkg::*;
#(
    parameter int N_CHILD = 3,
    parameter bit AGG_AND = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_cmd,
    input  logic               stop_cmd,
    input  logic               ev_normal,
    input  logic               ev_degraded,
    input  logic               ev_fault,
    input  logic               activity_done,
    input  logic [N_CHILD-1:0] child_ready,
    input  logic [N_CHILD-1:0] child_degraded,
    input  logic [N_CHILD-1:0] child_fault,
    output logic               act_req,
    output logic               wk_off,
    output logic               wk_armed,
    output logic               wk_on,
    output logic               wk_end,
    output logic               fn_normal,
    output logic               fn_degraded,
    output logic               fn_fault
);

    logic        agg_ready;
    logic        agg_degraded;
    logic        agg_fault;
    work_state_t wk_state;
    func_state_t fn_state;

    emc_child_agg #(
        .N_CHILD (N_CHILD),
        .AGG_AND (AGG_AND)
    ) u_agg (
        .child_ready    (child_ready),
        .child_degraded (child_degraded),
        .child_fault    (child_fault),
        .agg_ready      (agg_ready),
        .agg_degraded   (agg_degraded),
        .agg_fault      (agg_fault)
    );

    emc_func_region u_func (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit_normal   (ev_normal),
        .hit_degraded (ev_degraded | agg_degraded),
        .hit_fault    (ev_fault | agg_fault),
        .fn_state     (fn_state)
    );

    emc_work_region u_work (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_cmd     (start_cmd),
        .stop_cmd      (stop_cmd),
        .fault_now     (fn_state == FN_FAULT),
        .cond_ok       (agg_ready),
        .activity_done (activity_done),
        .wk_state      (wk_state),
        .act_req       (act_req)
    );

    // Decode each region into one flag per state.
    always_comb begin
        wk_off      = (wk_state == WK_OFF);
        wk_armed    = (wk_state == WK_ARMED);
        wk_on       = (wk_state == WK_ON);
        wk_end      = (wk_state == WK_END);
        fn_normal   = (fn_state == FN_NORMAL);
        fn_degraded = (fn_state == FN_DEGRADED);
        fn_fault    = (fn_state == FN_FAULT);
    end

endmodule

// File: rtl/emc_checker.sv
// Module emc_checker
// Temporal properties of the entity mode controller, bound to every instance.
// Assumes: port names match the top module so that .* connects them.
module emc_checker (
    input logic clk,
    input logic rst_n,
    input logic start_cmd,
    input logic stop_cmd,
    input logic ev_fault,
    input logic activity_done,
    input logic act_req,
    input logic wk_off,
    input logic wk_armed,
    input logic wk_on,
    input logic wk_end,
    input logic fn_normal,
    input logic fn_degraded,
    input logic fn_fault
);

    assert_work_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({wk_off, wk_armed, wk_on, wk_end}));

    assert_func_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({fn_normal, fn_degraded, fn_fault}));

    assert_no_start_in_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_off && fn_fault) |=> !wk_armed);

    assert_on_from_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wk_on) |-> $past(wk_armed));

    assert_end_to_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wk_end |=> wk_off);

    assert_done_to_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_on && activity_done && !stop_cmd && !fn_fault) |=> wk_end);

    assert_stop_to_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> wk_off);

    assert_fault_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fault |=> fn_fault);

    assert_fault_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_fault && (wk_armed || wk_on)) |=> wk_off);

    assert_req_needs_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_req) |-> $past(start_cmd));

endmodule

bind entity_mode_ctrl emc_checker u_chk (.*);

// File: tb/entity_mode_ctrl_bench.sv
// Bench entity_mode_ctrl_bench
// Directed scenarios on an AND instance and an OR instance that share inputs.
module entity_mode_ctrl_bench;

    localparam int NC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_cmd = 1'b0, stop_cmd = 1'b0;
    logic          ev_normal = 1'b0, ev_degraded = 1'b0, ev_fault = 1'b0;
    logic          activity_done = 1'b0;
    logic [NC-1:0] child_ready = '0, child_degraded = '0, child_fault = '0;

    logic a_req, a_off, a_arm, a_on, a_end, a_nrm, a_deg, a_flt;
    logic o_req, o_off, o_arm, o_on, o_end, o_nrm, o_deg, o_flt;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Expected flag patterns {off,armed,on,end} and {normal,degraded,fault}.
    localparam logic [3:0] W_OFF = 4'b1000, W_ARM = 4'b0100, W_ON = 4'b0010, W_END = 4'b0001;
    localparam logic [2:0] F_NRM = 3'b100, F_DEG = 3'b010, F_FLT = 3'b001;

    always #2 clk = ~clk;

    entity_mode_ctrl #(.N_CHILD(NC), .AGG_AND(1'b1)) u_entity_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .ev_normal(ev_normal), .ev_degraded(ev_degraded), .ev_fault(ev_fault),
        .activity_done(activity_done), .child_ready(child_ready),
        .child_degraded(child_degraded), .child_fault(child_fault),
        .act_req(a_req), .wk_off(a_off), .wk_armed(a_arm), .wk_on(a_on), .wk_end(a_end),
        .fn_normal(a_nrm), .fn_degraded(a_deg), .fn_fault(a_flt));

    entity_mode_ctrl #(.N_CHILD(NC), .AGG_AND(1'b0)) u_entity_mode_ctrl_or (
        .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .ev_normal(ev_normal), .ev_degraded(ev_degraded), .ev_fault(ev_fault),
        .activity_done(activity_done), .child_ready(child_ready),
        .child_degraded(child_degraded), .child_fault(child_fault),
        .act_req(o_req), .wk_off(o_off), .wk_armed(o_arm), .wk_on(o_on), .wk_end(o_end),
        .fn_normal(o_nrm), .fn_degraded(o_deg), .fn_fault(o_flt));

    // One rising edge, then back to the falling edge where inputs change.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Compare both instances against expected flags; act_req follows R10.
    task automatic expect_both(string req, logic [3:0] wa, logic [2:0] fa,
                               logic [3:0] wo, logic [2:0] fo);
        logic [7:0] act_a, exp_a, act_o, exp_o;
        act_a = {a_req, a_off, a_arm, a_on, a_end, a_nrm, a_deg, a_flt};
        exp_a = {(wa == W_ARM) || (wa == W_ON), wa, fa};
        act_o = {o_req, o_off, o_arm, o_on, o_end, o_nrm, o_deg, o_flt};
        exp_o = {(wo == W_ARM) || (wo == W_ON), wo, fo};
        checks++;
        if (act_a !== exp_a) begin
            errors++;
            $display("FAIL %s AND instance: actual %b expected %b", req, act_a, exp_a);
        end
        checks++;
        if (act_o !== exp_o) begin
            errors++;
            $display("FAIL %s OR instance: actual %b expected %b", req, act_o, exp_o);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        expect_both("R1 reset state (R9 one flag per region)", W_OFF, F_NRM, W_OFF, F_NRM);
    endtask

    task automatic t_activation();
        child_ready = 3'b000;
        start_cmd = 1'b1; tick(); start_cmd = 1'b0;
        expect_both("R2 start accepted, R10 request raised", W_ARM, F_NRM, W_ARM, F_NRM);
        tick();
        expect_both("R3 no child ready keeps armed", W_ARM, F_NRM, W_ARM, F_NRM);
        child_ready = 3'b001; tick();
        expect_both("R3 one child ready: OR runs, AND waits", W_ARM, F_NRM, W_ON, F_NRM);
        child_ready = 3'b111; tick();
        expect_both("R3 all children ready", W_ON, F_NRM, W_ON, F_NRM);
    endtask

    task automatic t_termination();
        activity_done = 1'b1; tick(); activity_done = 1'b0;
        expect_both("R4 done enters end state", W_END, F_NRM, W_END, F_NRM);
        tick();
        expect_both("R4 end returns to off", W_OFF, F_NRM, W_OFF, F_NRM);
        child_ready = 3'b000;
    endtask

    task automatic t_stop();
        start_cmd = 1'b1; stop_cmd = 1'b1; tick(); stop_cmd = 1'b0; start_cmd = 1'b0;
        expect_both("R5 stop beats simultaneous start", W_OFF, F_NRM, W_OFF, F_NRM);
        start_cmd = 1'b1; tick(); start_cmd = 1'b0;
        stop_cmd = 1'b1; tick(); stop_cmd = 1'b0;
        expect_both("R5 stop from armed", W_OFF, F_NRM, W_OFF, F_NRM);
    endtask

    task automatic t_health();
        ev_normal = 1'b1; ev_degraded = 1'b1; tick();
        ev_normal = 1'b0; ev_degraded = 1'b0;
        expect_both("R6 degraded beats normal", W_OFF, F_DEG, W_OFF, F_DEG);
        ev_normal = 1'b1; ev_degraded = 1'b1; ev_fault = 1'b1; tick();
        ev_normal = 1'b0; ev_degraded = 1'b0; ev_fault = 1'b0;
        expect_both("R6 fault beats degraded and normal", W_OFF, F_FLT, W_OFF, F_FLT);
        start_cmd = 1'b1; tick(); start_cmd = 1'b0;
        expect_both("R2 start ignored while faulted", W_OFF, F_FLT, W_OFF, F_FLT);
        ev_normal = 1'b1; tick(); ev_normal = 1'b0;
        expect_both("R6 normal event restores", W_OFF, F_NRM, W_OFF, F_NRM);
    endtask

    task automatic t_fault_while_on();
        child_ready = 3'b111;
        start_cmd = 1'b1; tick(); start_cmd = 1'b0;
        tick();
        expect_both("R3 running before fault", W_ON, F_NRM, W_ON, F_NRM);
        ev_fault = 1'b1; tick(); ev_fault = 1'b0;
        expect_both("R8 first edge: faulted, still running", W_ON, F_FLT, W_ON, F_FLT);
        tick();
        expect_both("R8 second edge: forced off", W_OFF, F_FLT, W_OFF, F_FLT);
        ev_normal = 1'b1; tick(); ev_normal = 1'b0;
        child_ready = 3'b000;
        expect_both("R6 recovery after forced stop", W_OFF, F_NRM, W_OFF, F_NRM);
    endtask

    task automatic t_child_health();
        child_fault = 3'b001; tick();
        expect_both("R7 one child faulted", W_OFF, F_FLT, W_OFF, F_DEG);
        child_fault = 3'b111; tick();
        expect_both("R7 all children faulted", W_OFF, F_FLT, W_OFF, F_FLT);
        child_fault = 3'b000; ev_normal = 1'b1; tick(); ev_normal = 1'b0;
        expect_both("R7 cleared children then normal", W_OFF, F_NRM, W_OFF, F_NRM);
        child_degraded = 3'b010; tick();
        expect_both("R7 one child degraded", W_OFF, F_DEG, W_OFF, F_DEG);
        child_degraded = 3'b000; ev_normal = 1'b1; tick(); ev_normal = 1'b0;
        expect_both("R7 degraded cleared then normal", W_OFF, F_NRM, W_OFF, F_NRM);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_activation();
        t_termination();
        t_stop();
        t_health();
        t_fault_while_on();
        t_child_health();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule